// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block takes over the DDR2 bring-up script that would otherwise be run by software. Once started, it waits for the impedance calibration of the pad buffers to report completion. It then issues, for each chip select from 0 up to a configured maximum index, a fixed list of thirteen 32-bit direct-command words toward the memory command path. Each word is offered with a valid/ready handshake and held until it is accepted.

The script sends:

- a NOP;
- precharge-all commands;
- writes to extended mode registers 2, 3 and 1;
- a mode-register write with DLL reset;
- three auto-refreshes;
- a mode-register write without DLL reset;
- a pair of extended-mode writes that first enter and then leave the OCD default state.

Idle gaps of programmable length separate the groups of commands. When the last word for the last chip has been accepted, the block drops busy and raises done. Done stays high until the next start.

Top module: `ddr2_init_seq`

## Requirements
- R1: Out of reset, cmd_valid_o, busy_o and done_o are all 0.
- R2: A start_i pulse seen while the block is idle begins a run: busy_o rises and done_o clears on the next cycle. The maximum chip index and the gap length are captured at that moment. A start_i seen while busy_o is high is ignored, together with any max_chip_i value presented with it.
- R3: After a start, no command is offered (cmd_valid_o stays 0) until cal_done_i is 1.
- R4: Every word has bits 31:22 at zero, so deep power-down (bit 22) is never requested. The chip select is in bits 21:20, the memory command in bits 19:18 (0 precharge-all, 1 auto-refresh, 2 mode/extended-mode register write, 3 NOP), the bank in bits 17:16 and the register address in bits 15:0.
- R5: For each chip c, the accepted words in order are:
  - NOP;
  - precharge-all;
  - register write on bank 2, then on bank 3, then on bank 1, each with address 0;
  - mode write with DLL reset;
  - precharge-all;
  - three auto-refreshes;
  - mode write without DLL reset;
  - OCD-default write;
  - OCD-exit write.

  Every one of these words carries c in bits 21:20.
- R6: The mode write with DLL reset is command 2, bank 0, address 0x742. This means burst length code 2, sequential, CAS latency 4, DLL reset in bit 8 and write recovery code 3 in bits 11:9. The mode write without DLL reset is the same with address 0x642.
- R7: The OCD-default write is command 2, bank 1, address 0x384: OCD field 111 in bits 9:7, termination bit 2 set, full drive strength. The OCD-exit write is command 2, bank 1, address 0x004.
- R8: A run emits exactly 13 × (max+1) words, for chips 0..max in increasing order, with max in 0..3.
- R9: After acceptance of the 2nd, 9th, 11th and 12th word of a chip, cmd_valid_o stays low for exactly max(gap_cycles_i, 10) cycles. Every other word is offered in the cycle right after the previous acceptance.
- R10: While cmd_valid_o is high and cmd_ready_i is low, the next cycle still has cmd_valid_o high and the same cmd_word_o. The sequence advances only on an accepted word.
- R11: In the cycle after the last word of the last chip is accepted, busy_o is 0 and done_o is 1. done_o then stays 1 until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse; acted on only while idle |
| max_chip_i | input | 2 | Highest chip select index to initialize |
| cal_done_i | input | 1 | Impedance calibration complete |
| gap_cycles_i | input | GAP_W | Requested gap length, floored at MIN_GAP |
| cmd_word_o | output | 32 | Direct-command word |
| cmd_valid_o | output | 1 | Command word valid |
| cmd_ready_i | input | 1 | Command path accepts the word |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Run finished; held until next start |

## Verification
The assertions make no assumption about cmd_ready_i, which the stimulus drives either constantly high or from a pseudo-random bit pattern. The calibration-gate property expects cal_done_i, once raised during a run, to stay high; the stimulus only ever raises it, sometimes tens of cycles after the start. A second start pulse with a different chip index is injected mid-run to show that the captured configuration holds. The sweep covers every chip count and gap requests below, at and above the floor.

// File: rtl/ddr2_init_pkg.sv
package ddr2_init_pkg;

  localparam int CMD_W    = 32;
  localparam int CHIP_W   = 2;
  localparam int STEP_CNT = 13;
  localparam int STEP_W   = $clog2(STEP_CNT);

  typedef enum logic [1:0] {
    MC_PALL = 2'd0,
    MC_AREF = 2'd1,
    MC_MRS  = 2'd2,
    MC_NOP  = 2'd3
  } memcmd_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_WAIT_CAL,
    S_ISSUE,
    S_GAP
  } seq_state_e;

  // Mode register address: burst length, CAS latency, DLL reset, write recovery
  function automatic logic [15:0] mr_addr(input logic [2:0] bl, input logic [2:0] cl,
                                          input logic dll_rst, input logic [2:0] wr);
    return {4'd0, wr, dll_rst, 1'b0, cl, 1'b0, bl};
  endfunction

  // Extended mode register address: OCD field and 75-ohm termination, full drive
  function automatic logic [15:0] emr_addr(input logic [2:0] ocd);
    return {6'd0, ocd, 7'b000_0100};
  endfunction

  function automatic logic [CMD_W-1:0] pack_cmd(input logic [CHIP_W-1:0] chip,
                                                input memcmd_e mc,
                                                input logic [1:0] bank,
                                                input logic [15:0] addr);
    return {9'd0, 1'b0, chip, mc, bank, addr};
  endfunction

  function automatic logic [CMD_W-1:0] step_word(input logic [CHIP_W-1:0] chip,
                                                 input logic [STEP_W-1:0] step);
    memcmd_e     mc;
    logic [1:0]  bk;
    logic [15:0] ad;
    mc = MC_MRS;
    bk = 2'd0;
    ad = 16'd0;
    case (step)
      4'd0:              mc = MC_NOP;
      4'd1, 4'd6:        mc = MC_PALL;
      4'd2:              bk = 2'd2;
      4'd3:              bk = 2'd3;
      4'd4:              bk = 2'd1;
      4'd5:              ad = mr_addr(3'd2, 3'd4, 1'b1, 3'd3);
      4'd7, 4'd8, 4'd9:  mc = MC_AREF;
      4'd10:             ad = mr_addr(3'd2, 3'd4, 1'b0, 3'd3);
      4'd11: begin       bk = 2'd1; ad = emr_addr(3'b111); end
      4'd12: begin       bk = 2'd1; ad = emr_addr(3'b000); end
      default:           mc = MC_NOP;
    endcase
    return pack_cmd(chip, mc, bk, ad);
  endfunction

  // Steps followed by an idle gap
  function automatic logic step_gap(input logic [STEP_W-1:0] step);
    return (step == 4'd1) || (step == 4'd8) || (step == 4'd10) || (step == 4'd11);
  endfunction

endpackage

// File: rtl/ddr2_init_word_gen.sv
module ddr2_init_word_gen
  import ddr2_init_pkg::*;
(
  input  logic [CHIP_W-1:0] chip_i,
  input  logic [STEP_W-1:0] step_i,
  output logic [CMD_W-1:0]  word_o
);

  always_comb word_o = step_word(chip_i, step_i);

endmodule

// File: rtl/ddr2_init_gap_timer.sv
module ddr2_init_gap_timer #(
  parameter int GAP_W   = 16,
  parameter int MIN_GAP = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [GAP_W-1:0] req_i,
  output logic             last_o
);

  localparam logic [GAP_W-1:0] FLOOR = GAP_W'(MIN_GAP);
  localparam logic [GAP_W-1:0] ONE   = GAP_W'(1);

  logic [GAP_W-1:0] cnt_q;
  logic [GAP_W-1:0] eff_len;

  always_comb eff_len = (req_i < FLOOR) ? FLOOR : req_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load_i)        cnt_q <= eff_len;
    else if (cnt_q != '0)   cnt_q <= cnt_q - ONE;
  end

  assign last_o = (cnt_q == ONE);

  AST_GAP_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_q >= FLOOR)); // R9

  AST_GAP_COUNTS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - ONE)); // R9

endmodule

// File: rtl/ddr2_init_seq_fsm.sv
module ddr2_init_seq_fsm
  import ddr2_init_pkg::*;
#(
  parameter int GAP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [CHIP_W-1:0] max_chip_i,
  input  logic              cal_done_i,
  input  logic [GAP_W-1:0]  gap_cycles_i,
  input  logic              cmd_ready_i,
  input  logic              gap_last_i,
  output logic              cmd_valid_o,
  output logic [STEP_W-1:0] step_o,
  output logic [CHIP_W-1:0] chip_o,
  output logic              gap_load_o,
  output logic [GAP_W-1:0]  gap_len_o,
  output logic              busy_o,
  output logic              done_o
);

  localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(STEP_CNT - 1);
  localparam logic [STEP_W-1:0] STEP_ONE  = STEP_W'(1);
  localparam logic [CHIP_W-1:0] CHIP_ONE  = CHIP_W'(1);

  seq_state_e        state_q;
  logic [STEP_W-1:0] step_q;
  logic [CHIP_W-1:0] chip_q;
  logic [CHIP_W-1:0] max_q;
  logic [GAP_W-1:0]  gap_q;
  logic              done_q;

  // Named internal events
  logic hs, last_step, last_chip, seq_end, take_gap, start_ok;
  assign hs        = cmd_valid_o && cmd_ready_i;
  assign last_step = (step_q == STEP_LAST);
  assign last_chip = (chip_q == max_q);
  assign seq_end   = hs && last_step && last_chip;
  assign take_gap  = hs && step_gap(step_q);
  assign start_ok  = (state_q == S_IDLE) && start_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      step_q  <= '0;
      chip_q  <= '0;
      max_q   <= '0;
      gap_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE: if (start_i) begin
          state_q <= S_WAIT_CAL;
          step_q  <= '0;
          chip_q  <= '0;
          max_q   <= max_chip_i;
          gap_q   <= gap_cycles_i;
          done_q  <= 1'b0;
        end
        S_WAIT_CAL: if (cal_done_i) state_q <= S_ISSUE;
        S_ISSUE: if (hs) begin
          if (seq_end) begin
            state_q <= S_IDLE;
            done_q  <= 1'b1;
          end else if (take_gap) begin
            state_q <= S_GAP;
          end else if (last_step) begin
            step_q <= '0;
            chip_q <= chip_q + CHIP_ONE;
          end else begin
            step_q <= step_q + STEP_ONE;
          end
        end
        S_GAP: if (gap_last_i) begin
          state_q <= S_ISSUE;
          step_q  <= step_q + STEP_ONE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign cmd_valid_o = (state_q == S_ISSUE);
  assign step_o      = step_q;
  assign chip_o      = chip_q;
  assign gap_load_o  = take_gap;
  assign gap_len_o   = gap_q;
  assign busy_o      = (state_q != S_IDLE);
  assign done_o      = done_q;

  AST_CAL_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_WAIT_CAL && !cal_done_i) |=> !cmd_valid_o); // R3

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> ($stable(max_q) && $stable(gap_q))); // R2

  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |=> (busy_o && !done_o)); // R2

  AST_CHIP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |-> (chip_q <= max_q)); // R8

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o); // R11

  AST_DONE_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
    seq_end |=> (done_o && !busy_o)); // R11

  AST_STEP_ON_HS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && !cmd_ready_i) |=> ($stable(step_q) && $stable(chip_q))); // R10

endmodule

// File: rtl/ddr2_init_seq.sv
module ddr2_init_seq
  import ddr2_init_pkg::*;
#(
  parameter int GAP_W   = 16,
  parameter int MIN_GAP = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [CHIP_W-1:0] max_chip_i,
  input  logic              cal_done_i,
  input  logic [GAP_W-1:0]  gap_cycles_i,
  output logic [CMD_W-1:0]  cmd_word_o,
  output logic              cmd_valid_o,
  input  logic              cmd_ready_i,
  output logic              busy_o,
  output logic              done_o
);

  logic [STEP_W-1:0] step;
  logic [CHIP_W-1:0] chip;
  logic              gap_load;
  logic              gap_last;
  logic [GAP_W-1:0]  gap_len;

  ddr2_init_seq_fsm #(.GAP_W(GAP_W)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .max_chip_i   (max_chip_i),
    .cal_done_i   (cal_done_i),
    .gap_cycles_i (gap_cycles_i),
    .cmd_ready_i  (cmd_ready_i),
    .gap_last_i   (gap_last),
    .cmd_valid_o  (cmd_valid_o),
    .step_o       (step),
    .chip_o       (chip),
    .gap_load_o   (gap_load),
    .gap_len_o    (gap_len),
    .busy_o       (busy_o),
    .done_o       (done_o)
  );

  ddr2_init_gap_timer #(.GAP_W(GAP_W), .MIN_GAP(MIN_GAP)) u_gap (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (gap_load),
    .req_i  (gap_len),
    .last_o (gap_last)
  );

  ddr2_init_word_gen u_word (
    .chip_i (chip),
    .step_i (step),
    .word_o (cmd_word_o)
  );

  AST_HOLD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && !cmd_ready_i) |=> (cmd_valid_o && $stable(cmd_word_o))); // R10

  AST_NO_DEEP_PD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |-> (cmd_word_o[31:22] == 10'd0)); // R4

  AST_VALID_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |-> busy_o); // R3

endmodule

// File: tb/test_ddr2_init_seq.sv
module test_ddr2_init_seq;

  localparam int GW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [1:0]    max_chip_i = 2'd0;
  logic          cal_done_i = 1'b0;
  logic [GW-1:0] gap_cycles_i = '0;
  logic [31:0]   cmd_word_o;
  logic          cmd_valid_o;
  logic          cmd_ready_i = 1'b1;
  logic          busy_o;
  logic          done_o;

  ddr2_init_seq #(.GAP_W(GW), .MIN_GAP(10)) i_ddr2_init_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .max_chip_i(max_chip_i),
    .cal_done_i(cal_done_i), .gap_cycles_i(gap_cycles_i), .cmd_word_o(cmd_word_o),
    .cmd_valid_o(cmd_valid_o), .cmd_ready_i(cmd_ready_i), .busy_o(busy_o), .done_o(done_o)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cyc_all = 0;
  bit wd = 1'b0;

  // monitor state
  int          ready_mode = 0;
  logic [7:0]  lfsr = 8'hA5;
  logic [31:0] got [0:63];
  int          gap_seen [0:63];
  int          nw = 0;
  int          idle = 0;
  bit          prev_stall = 1'b0;
  logic [31:0] prev_word = '0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_word(input int c, input int s);
    int cmd, bank, addr;
    cmd = 2; bank = 0; addr = 0;
    case (s)
      0: cmd = 3;
      1, 6: cmd = 0;
      2: bank = 2;
      3: bank = 3;
      4: bank = 1;
      5: addr = 2 + 4 * 16 + 256 + 3 * 512;
      7, 8, 9: cmd = 1;
      10: addr = 2 + 4 * 16 + 3 * 512;
      11: begin bank = 1; addr = 7 * 128 + 4; end
      12: begin bank = 1; addr = 4; end
      default: cmd = 3;
    endcase
    return 32'(c * 1048576 + cmd * 262144 + bank * 65536 + addr);
  endfunction

  function automatic bit ref_gap_after(input int s);
    return (s == 1) || (s == 8) || (s == 10) || (s == 11);
  endfunction

  function automatic string tag_of(input int s);
    if (s == 5 || s == 10) return "R6";
    if (s == 11 || s == 12) return "R7";
    return "R5";
  endfunction

  // Monitor: drive ready first, then sample what the next edge will take
  always @(negedge clk) begin
    if (ready_mode == 0) cmd_ready_i = 1'b1;
    else begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      cmd_ready_i = lfsr[0];
    end
    if (rst_n) begin
      if (prev_stall)
        chk(cmd_valid_o && (cmd_word_o == prev_word), "R10 hold", cmd_word_o, prev_word);
      prev_stall = cmd_valid_o && !cmd_ready_i;
      prev_word  = cmd_word_o;
      if (cmd_valid_o && cmd_ready_i) begin
        if (nw < 64) begin
          got[nw] = cmd_word_o;
          gap_seen[nw] = idle;
        end
        nw++;
        idle = 0;
      end else if (!cmd_valid_o && busy_o && nw > 0) begin
        idle++;
      end
    end
  end

  task automatic run(input int mc, input int gp, input int rmode, input int caldly, input bit poke);
    int cyc, expn, eg;
    @(negedge clk);
    max_chip_i = 2'(mc);
    gap_cycles_i = GW'(gp);
    ready_mode = rmode;
    cal_done_i = (caldly == 0);
    nw = 0;
    idle = 0;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o && !done_o, "R2 start accepted / R11 done cleared", {busy_o, done_o}, 2'b10);
    if (caldly > 0) begin
      for (int k = 0; k < caldly; k++) begin
        @(negedge clk);
        if (cmd_valid_o) chk(1'b0, "R3 valid before calibration", 1, 0);
      end
      chk(nw == 0 && busy_o, "R3 waiting for calibration", nw, 0);
      cal_done_i = 1'b1;
    end
    cyc = 0;
    while (!done_o && !wd) begin
      @(negedge clk);
      cyc++;
      if (poke && cyc == 20) begin start_i = 1'b1; max_chip_i = 2'(3 - mc); end
      if (poke && cyc == 21) begin start_i = 1'b0; max_chip_i = 2'(mc); end
    end
    start_i = 1'b0;
    max_chip_i = 2'(mc);
    chk(!busy_o && done_o, "R11 end state", {busy_o, done_o}, 2'b01);
    expn = 13 * (mc + 1);
    chk(nw == expn, poke ? "R2 start ignored while busy (word count)" : "R8 word count", nw, expn);
    for (int k = 0; k < expn && k < nw; k++) begin
      chk(got[k] == ref_word(k / 13, k % 13), tag_of(k % 13), got[k], ref_word(k / 13, k % 13));
      if (k > 0) begin
        eg = ref_gap_after((k - 1) % 13) ? ((gp < 10) ? 10 : gp) : 0;
        chk(gap_seen[k] == eg, "R9 gap", gap_seen[k], eg);
      end
    end
    if (nw > 0) chk(got[nw - 1][31:22] == 10'd0, "R4 upper bits clear", got[nw - 1][31:22], 0);
    repeat (5) @(negedge clk);
    chk(done_o && !busy_o && !cmd_valid_o, "R11 done held", {done_o, busy_o, cmd_valid_o}, 3'b100);
  endtask

  always @(posedge clk) begin
    cyc_all++;
    if (cyc_all > 150000 && !wd) begin
      wd = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc_all);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int gaps [3];
    gaps[0] = 0; gaps[1] = 10; gaps[2] = 23;
    repeat (3) @(negedge clk);
    chk(!cmd_valid_o && !busy_o && !done_o, "R1 reset state", {cmd_valid_o, busy_o, done_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!cmd_valid_o && !busy_o && !done_o, "R1 after reset release", {cmd_valid_o, busy_o, done_o}, 0);
    for (int mc = 0; mc < 4; mc++)
      for (int gi = 0; gi < 3; gi++)
        for (int rm = 0; rm < 2; rm++)
          run(mc, gaps[gi], rm, (mc == 2 && gi == 0) ? 40 : 0, (rm == 1 && gi == 1));
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule